// File: doc/BRIEF.md
# Cascaded Time-Multiplexed Vector Adder

This block adds up a vector of signed two's-complement words. It does not build a full parallel adder tree. The vector is cut into equal contiguous groups, and each group has a single accumulator that takes one element per fast step. Every master-clock cycle is a fast step by default. After a whole sample period the group totals are added together, and the result is registered onto the output. A small timing controller runs on the one master clock. It derives a fast step enable and a slow sample enable from a phase counter, so the design trades adder count for oversampled cycles.

The block is used as follows. The surrounding logic holds a vector on `vec_in` and watches `sample_en`. The vector is taken in at the rising edge where `sample_en` is high. After a fixed latency the exact total appears on `sum_out`, together with a one-cycle `out_valid` pulse. Guard bits make the total wide enough that no combination of inputs can overflow.

Top module: `cascade_vsum`

## Requirements
- R1: A synchronous active-high `rst` clears all counters, group totals and the output register. While in reset and right after it, `sum_out` is 0 and `out_valid` is 0.
- R2: `sample_en` is high for exactly one cycle in every period of OSR = N_IN/GROUPS cycles (4 by default). It first goes high in the cycle after the third rising edge that follows reset release.
- R3: `vec_in` is taken in only at a rising edge where `sample_en` is high. Values on `vec_in` at every other edge have no effect on any later `sum_out`.
- R4: `sum_out` equals the exact signed sum of all N_IN elements, where element i occupies `vec_in[i*W +: W]` in two's complement. The sum is given sign-extended to W+GUARD bits and matches bit for bit, including all-maximum and all-minimum vectors.
- R5: The total of a vector taken in at edge e is presented on `sum_out` after edge e+OSR+1, which is edge e+5 by default.
- R6: `out_valid` is a single-cycle pulse that is high exactly in the cycle a new total first shows on `sum_out`, once per sample period. No pulse occurs before the first vector taken in after reset has been fully summed.
- R7: Between `out_valid` pulses, `sum_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| vec_in | input | N_IN*W | Packed input vector, element i at bits i*W+W-1 : i*W |
| sample_en | output | 1 | Sample strobe; vec_in is taken in at the following rising edge |
| sum_out | output | W+GUARD | Signed total of the last completed vector |
| out_valid | output | 1 | One-cycle pulse marking a new total |

## Verification
A mistake in the phase counter or the group multiplexers shows up as a wrong total on the first `out_valid` pulse after the faulty step. That pulse comes at most OSR+1 cycles after the affected vector is taken in. A wrongly timed enable moves either `sample_en` or the valid pulse away from its expected cycle, and the bench compares both on every clock. Random data on `vec_in` between sample strobes makes a capture at the wrong edge appear as a mismatched total one period later. Extreme vectors expose a missing guard bit or a faulty sign extension.

// File: rtl/cascade_vsum_pkg.sv
package cascade_vsum_pkg;

   // Number of extra bits needed so that n_terms full-scale words cannot overflow
   function automatic int guard_needed(input int n_terms);
      return (n_terms <= 1) ? 0 : $clog2(n_terms);
   endfunction

   // Width of a counter that counts 0 .. n-1
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cvs_timing.sv
module cvs_timing
   import cascade_vsum_pkg::*;
#(
   parameter int OSR      = 4,
   parameter int FAST_DIV = 1,
   localparam int PW      = cnt_width(OSR)
) (
   input  logic          clk,
   input  logic          rst,
   output logic          fast_en,
   output logic          sample_en,
   output logic          result_due,
   output logic [PW-1:0] phase
);

   localparam logic [PW-1:0] LAST_PH = PW'(OSR - 1);

   generate
      if (OSR < 2) begin : g_bad_osr
         $error("cvs_timing: OSR must be at least 2");
      end
      if (FAST_DIV < 1) begin : g_bad_div
         $error("cvs_timing: FAST_DIV must be at least 1");
      end
   endgenerate

   // Fast-rate enable: every cycle, or a prescaled strobe
   generate
      if (FAST_DIV == 1) begin : g_nodiv
         assign fast_en = 1'b1;
      end else begin : g_div
         localparam int DW = cnt_width(FAST_DIV);
         logic [DW-1:0] div_cnt;
         always_ff @(posedge clk) begin
            if (rst)                                div_cnt <= '0;
            else if (div_cnt == DW'(FAST_DIV - 1))  div_cnt <= '0;
            else                                    div_cnt <= div_cnt + DW'(1);
         end
         assign fast_en = (div_cnt == DW'(FAST_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                 phase <= '0;
      else if (fast_en) begin
         if (phase == LAST_PH) phase <= '0;
         else                  phase <= phase + PW'(1);
      end
   end

   logic load_en;
   logic cap_v;   // a real vector has been taken in
   logic acc_v;   // the group totals now being built come from a real vector

   assign load_en   = fast_en && (phase == '0);
   assign sample_en = fast_en && (phase == LAST_PH);

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_v <= 1'b0;
         acc_v <= 1'b0;
      end else begin
         if (sample_en) cap_v <= 1'b1;
         if (load_en)   acc_v <= cap_v;
      end
   end

   assign result_due = load_en && acc_v;

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
      sample_en |=> !sample_en);

   assert_no_early_result_R6: assert property (@(posedge clk) disable iff (rst)
      result_due |-> cap_v);

endmodule

// File: rtl/cvs_group_acc.sv
module cvs_group_acc #(
   parameter int W     = 16,
   parameter int GSIZE = 4,
   parameter int SW    = 20,
   parameter int PW    = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    fast_en,
   input  logic [PW-1:0]           phase,
   input  logic [GSIZE*W-1:0]      grp_vec,
   output logic signed [SW-1:0]    part
);

   localparam longint LO_L = -(longint'(GSIZE) <<< (W - 1));
   localparam longint HI_L = longint'(GSIZE) * ((longint'(1) <<< (W - 1)) - 1);

   generate
      if (SW < W) begin : g_bad_w
         $error("cvs_group_acc: SW must not be narrower than W");
      end
   endgenerate

   logic [W-1:0]         elem;
   logic signed [SW-1:0] elem_x;

   // Select this step's element and sign-extend it
   assign elem   = grp_vec[int'(phase)*W +: W];
   assign elem_x = SW'($signed(elem));

   // Phase 0 reloads the accumulator, later phases add into it
   always_ff @(posedge clk) begin
      if (rst)                  part <= '0;
      else if (fast_en) begin
         if (phase == '0)       part <= elem_x;
         else                   part <= part + elem_x;
      end
   end

   assert_partial_bound_R4: assert property (@(posedge clk) disable iff (rst)
      (longint'(part) >= LO_L) && (longint'(part) <= HI_L));

endmodule

// File: rtl/cvs_combine.sv
module cvs_combine #(
   parameter int GROUPS = 3,
   parameter int SW     = 20
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     result_due,
   input  logic [GROUPS*SW-1:0]     parts,
   output logic signed [SW-1:0]     sum_out,
   output logic                     out_valid
);

   logic signed [SW-1:0] total;

   always_comb begin
      total = '0;
      for (int g = 0; g < GROUPS; g++) begin
         total = total + $signed(parts[g*SW +: SW]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_out   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= result_due;
         if (result_due) sum_out <= total;
      end
   end

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_sum_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(sum_out));

endmodule

// File: rtl/cascade_vsum.sv
module cascade_vsum
   import cascade_vsum_pkg::*;
#(
   parameter int N_IN     = 12,
   parameter int W        = 16,
   parameter int GROUPS   = 3,
   parameter int GUARD    = 4,
   parameter int FAST_DIV = 1,
   localparam int OSR     = N_IN / GROUPS,
   localparam int SW      = W + GUARD,
   localparam int PW      = cnt_width(OSR)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_IN*W-1:0]      vec_in,
   output logic                   sample_en,
   output logic signed [SW-1:0]   sum_out,
   output logic                   out_valid
);

   generate
      if (N_IN % GROUPS != 0) begin : g_bad_split
         $error("cascade_vsum: N_IN must divide evenly into GROUPS");
      end
      if (GUARD < guard_needed(N_IN)) begin : g_bad_guard
         $error("cascade_vsum: GUARD too small for an exact sum");
      end
   endgenerate

   logic                  fast_en;
   logic                  result_due;
   logic [PW-1:0]         phase;
   logic [N_IN*W-1:0]     vec_q;
   logic [GROUPS*SW-1:0]  parts;

   cvs_timing #(
      .OSR      (OSR),
      .FAST_DIV (FAST_DIV)
   ) u_timing (
      .clk        (clk),
      .rst        (rst),
      .fast_en    (fast_en),
      .sample_en  (sample_en),
      .result_due (result_due),
      .phase      (phase)
   );

   // Input vector register, loaded only on the slow enable
   always_ff @(posedge clk) begin
      if (rst)            vec_q <= '0;
      else if (sample_en) vec_q <= vec_in;
   end

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         cvs_group_acc #(
            .W     (W),
            .GSIZE (OSR),
            .SW    (SW),
            .PW    (PW)
         ) u_acc (
            .clk     (clk),
            .rst     (rst),
            .fast_en (fast_en),
            .phase   (phase),
            .grp_vec (vec_q[g*OSR*W +: OSR*W]),
            .part    (parts[g*SW +: SW])
         );
      end
   endgenerate

   cvs_combine #(
      .GROUPS (GROUPS),
      .SW     (SW)
   ) u_comb (
      .clk        (clk),
      .rst        (rst),
      .result_due (result_due),
      .parts      (parts),
      .sum_out    (sum_out),
      .out_valid  (out_valid)
   );

   assert_capture_only_R3: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> $stable(vec_q));

endmodule

// File: tb/cascade_vsum_tb.sv
module cascade_vsum_tb;

   localparam int N   = 12;
   localparam int W   = 16;
   localparam int SW  = 20;
   localparam int OSR = 4;
   localparam int LAT = OSR + 2;   // strobe cycle to result cycle
   localparam int NCYC = 200;

   logic                 clk = 1'b0;
   logic                 rst;
   logic [N*W-1:0]       vec_in;
   logic                 sample_en;
   logic signed [SW-1:0] sum_out;
   logic                 out_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {int due; longint val;} pend_t;
   pend_t q[$];

   always #10 clk = ~clk;

   cascade_vsum u_dut (
      .clk       (clk),
      .rst       (rst),
      .vec_in    (vec_in),
      .sample_en (sample_en),
      .sum_out   (sum_out),
      .out_valid (out_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint vsum(input logic [N*W-1:0] v);
      longint s = 0;
      for (int i = 0; i < N; i++) s += longint'($signed(v[i*W +: W]));
      return s;
   endfunction

   function automatic logic [N*W-1:0] rand_vec();
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      return v;
   endfunction

   function automatic logic [N*W-1:0] pattern(input int k);
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) begin
         case (k)
            0:       v[i*W +: W] = 16'sh7FFF;
            1:       v[i*W +: W] = 16'sh8000;
            2:       v[i*W +: W] = (i % 2 == 0) ? 16'sh7FFF : 16'sh8000;
            3:       v[i*W +: W] = '0;
            4:       v[i*W +: W] = (i == N - 1) ? 16'shFFFF : 16'sh0000;
            5:       v[i*W +: W] = W'(i + 1);
            default: v[i*W +: W] = W'($urandom);
         endcase
      end
      return v;
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      longint last = 0;
      rst    = 1'b1;
      vec_in = rand_vec();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(sum_out == '0, "R1", "sum_out in reset", longint'(sum_out), 0);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
      rst = 1'b0;
      for (int n = 0; n < NCYC; n++) begin
         // n rising edges have occurred since reset release
         chk(sample_en == (n % OSR == OSR - 1), "R2", "sample_en",
             longint'(sample_en), longint'(n % OSR == OSR - 1));
         if (q.size() > 0 && q[0].due == n) begin
            chk(out_valid == 1'b1, "R6", "out_valid pulse", longint'(out_valid), 1);
            chk(longint'(sum_out) == q[0].val, "R4", "sum value",
                longint'(sum_out), q[0].val);
            chk(longint'(sum_out) == q[0].val, "R5", "result timing",
                longint'(sum_out), q[0].val);
            last = q[0].val;
            void'(q.pop_front());
         end else begin
            chk(out_valid == 1'b0, "R6", "no pulse", longint'(out_valid), 0);
            chk(longint'(sum_out) == last, "R7", "hold", longint'(sum_out), last);
         end
         // R3: data outside the sample edge is random noise
         if (n % OSR == OSR - 1) begin
            vec_in = pattern(n / OSR);
            q.push_back('{due: n + LAT, val: vsum(vec_in)});
         end else begin
            vec_in = rand_vec();
         end
         @(negedge clk);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule